// File: doc/BRIEF.md
# Four-Phase Ring Slot Sequencer

This block runs a small slot memory of sixteen 12-bit words, each holding a 4-bit state and an 8-bit count. Every RAM cycle takes four clocks, and each clock is one phase that either reads or conditionally writes. A free-running pointer sweeps the slots: each slot is read, its next value is formed, and that value is written back one RAM cycle later. The count drops by one on each pass when the external decode asks for a decrement, and the state is replaced by the state the decode supplies.

A host can also place a command into any slot. It presents a 16-bit word and pulses a load strobe. Within the next RAM cycles the block reads the addressed slot, adds the host count to it, takes the host state, and writes the result back in the load-address write phase. The addressed slot is read back once per RAM cycle so that its state and count, and a registered zero flag, are always visible at the outputs. Pulling `run` low holds the sequencer in its read phase, marks a command as pending and clears the wake request.

Top module: `ring_slot_sequencer`

## Requirements
- R1: While `run` is high the phase output steps one phase per clock in the order 1, 0, 3, 2 and then back to 1; the phase output value equals the phase number.
- R2: At the phase-1 edge the 4-bit sweep pointer increments modulo 16, and the working word is written to the slot at the old pointer only when the delayed load flag is clear.
- R3: The phase-0 edge loads the ring registers from the slot at the (already incremented) sweep pointer; the phase-2 edge loads them from the slot at the host load address. The working word is refreshed with the next word at both edges.
- R4: On `host_load` the host word is captured with state in bits [3:0], count in bits [11:4] and slot address in bits [15:12], and a command is marked pending.
- R5: While the load flag is set, the next word takes the host state and the ring count plus the host count modulo 256; the phase-3 edge writes the working word to the slot at the host address only while the delayed load flag is set.
- R6: While the load flag is clear, the next word takes `dec_state` and the ring count minus `dec_req` modulo 256, so with `dec_req` high every slot's count drops by exactly one per 16 RAM cycles and wraps from 0 to 255.
- R7: At the phase-0 edge the delayed load flag takes the load flag and the load flag clears; at the phase-2 edge a pending command sets the load flag and is consumed. A loaded slot is thus visible at the ring outputs eight clocks after a strobe taken at a phase-1 edge, and still shows the old count four clocks after it.
- R8: When `run` is low the next phase is phase 0, a command is marked pending, the wake request clears and the sweep pointer holds; when `run` returns the pending command performs a load with the held host word.
- R9: `ring_zero` is registered together with the ring count and is high exactly when all eight count bits are zero.
- R10: `wake_req` is set at a phase-2 edge when `dec_set_wake` is high and then holds until `run` goes low or reset.
- R11: Synchronous reset puts the sequencer in phase 1 with pointer 0, all slots and ring registers zero, `ring_zero` high and no wake request or pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one phase per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Low holds the sequencer in phase 0 and forces a pending command |
| host_load | input | 1 | Strobe that captures `host_word` |
| host_word | input | 16 | Host command: address [15:12], count [11:4], state [3:0] |
| dec_state | input | 4 | Next state from the external state decode |
| dec_req | input | 1 | Decrement request from the external state decode |
| dec_set_wake | input | 1 | Wake set request from the external state decode |
| phase_o | output | 2 | Current phase number |
| ptr_o | output | 4 | Sweep pointer |
| ring_state_o | output | 4 | Ring state register |
| ring_cnt_o | output | 8 | Ring count register |
| ring_zero_o | output | 1 | Registered zero flag of the ring count |
| wake_req_o | output | 1 | Wake request |

## Verification
On every clock the assertions check the phase rotation, the forced read phase and cleared wake while `run` is low, the pointer stepping only at phase 1, the handover of the load flag into its delayed copy at phase 0, that the load flag only rises out of phase 2, and the agreement of the zero flag with the ring count. The arithmetic of the slots can only be seen through the bench's scenarios: accumulation of host counts into a slot with 8-bit wrap, the exact clock at which a loaded slot appears, one decrement per sweep with wrap from 0 to 255, the state taken from the decode, and the replayed load after `run` is released.

// File: rtl/ring_seq_pkg.sv
`timescale 1ns/1ps
package ring_seq_pkg;
    localparam int SLOT_AW = 4;
    localparam int STATE_W = 4;
    localparam int CNT_W   = 8;
    localparam int HOST_W  = SLOT_AW + CNT_W + STATE_W;
    localparam int SLOTS   = 1 << SLOT_AW;

    typedef enum logic [1:0] {
        PH0 = 2'd0,
        PH1 = 2'd1,
        PH2 = 2'd2,
        PH3 = 2'd3
    } phase_e;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic [CNT_W-1:0]   cnt;
    } slot_t;

    typedef struct packed {
        logic [SLOT_AW-1:0] addr;
        logic [CNT_W-1:0]   cnt;
        logic [STATE_W-1:0] state;
    } host_t;

    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH1:     return PH0;
            PH0:     return PH3;
            PH3:     return PH2;
            default: return PH1;
        endcase
    endfunction

    function automatic logic cnt_is_zero(input logic [CNT_W-1:0] c);
        return c == '0;
    endfunction
endpackage

// File: rtl/ring_phase_ctl.sv
`timescale 1ns/1ps
module ring_phase_ctl
    import ring_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    output phase_e phase_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= PH1;
        end else if (!run) begin
            phase_o <= PH0;
        end else begin
            phase_o <= phase_after(phase_o);
        end
    end
endmodule

// File: rtl/ring_slot_store.sv
`timescale 1ns/1ps
module ring_slot_store
    import ring_seq_pkg::*;
#(
    parameter int AW = SLOT_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  slot_t         wr_data,
    input  logic [AW-1:0] rd_addr,
    output slot_t         rd_data
);
    localparam int DEPTH = 1 << AW;

    slot_t             mem [DEPTH];
    logic [DEPTH-1:0]  wr_hit;

    for (genvar s = 0; s < DEPTH; s++) begin : g_hit
        assign wr_hit[s] = wr_en && (wr_addr == AW'(s));
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (rst) begin
                mem[s] <= '0;
            end else if (wr_hit[s]) begin
                mem[s] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ring_next_word.sv
`timescale 1ns/1ps
module ring_next_word
    import ring_seq_pkg::*;
(
    input  logic               load_active,
    input  slot_t              ring,
    input  host_t              host,
    input  logic [STATE_W-1:0] dec_state,
    input  logic               dec_req,
    output slot_t              nxt
);
    always_comb begin
        if (load_active) begin
            nxt.state = host.state;
            nxt.cnt   = ring.cnt + host.cnt;
        end else begin
            nxt.state = dec_state;
            nxt.cnt   = ring.cnt - CNT_W'(dec_req);
        end
    end
endmodule

// File: rtl/ring_slot_sequencer.sv
`timescale 1ns/1ps
module ring_slot_sequencer
    import ring_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               host_load,
    input  logic [HOST_W-1:0]  host_word,
    input  logic [STATE_W-1:0] dec_state,
    input  logic               dec_req,
    input  logic               dec_set_wake,
    output logic [1:0]         phase_o,
    output logic [SLOT_AW-1:0] ptr_o,
    output logic [STATE_W-1:0] ring_state_o,
    output logic [CNT_W-1:0]   ring_cnt_o,
    output logic               ring_zero_o,
    output logic               wake_req_o
);
    phase_e             phase;
    logic [SLOT_AW-1:0] ptr_q;
    host_t              host_q;
    logic               new_cmd;
    logic               load_flag;
    logic               dly_load;
    slot_t              work_q;
    slot_t              ring_q;
    logic               ring_zero_q;
    logic               wake_q;
    slot_t              rd_data;
    slot_t              nxt;
    logic               wr_en;
    logic [SLOT_AW-1:0] wr_addr;
    logic [SLOT_AW-1:0] rd_addr;

    ring_phase_ctl u_phase (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .phase_o (phase)
    );

    // Phase 1 writes back the sweep slot; phase 3 writes the host slot.
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = host_q.addr;
        if (run && phase == PH1) begin
            wr_en   = !dly_load;
            wr_addr = ptr_q;
        end else if (run && phase == PH3) begin
            wr_en   = dly_load;
        end
    end

    assign rd_addr = (phase == PH0) ? ptr_q : host_q.addr;

    ring_slot_store #(.AW(SLOT_AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (work_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    ring_next_word u_next (
        .load_active (load_flag),
        .ring        (ring_q),
        .host        (host_q),
        .dec_state   (dec_state),
        .dec_req     (dec_req),
        .nxt         (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q       <= '0;
            host_q      <= '0;
            new_cmd     <= 1'b0;
            load_flag   <= 1'b0;
            dly_load    <= 1'b0;
            work_q      <= '0;
            ring_q      <= '0;
            ring_zero_q <= 1'b1;
            wake_q      <= 1'b0;
        end else begin
            if (!run) begin
                new_cmd <= 1'b1;
                wake_q  <= 1'b0;
            end else begin
                case (phase)
                    PH1: ptr_q <= ptr_q + SLOT_AW'(1);
                    PH0: begin
                        dly_load    <= load_flag;
                        load_flag   <= 1'b0;
                        work_q      <= nxt;
                        ring_q      <= rd_data;
                        ring_zero_q <= cnt_is_zero(rd_data.cnt);
                    end
                    PH2: begin
                        work_q      <= nxt;
                        ring_q      <= rd_data;
                        ring_zero_q <= cnt_is_zero(rd_data.cnt);
                        if (new_cmd) begin
                            load_flag <= 1'b1;
                            new_cmd   <= 1'b0;
                        end
                        if (dec_set_wake) begin
                            wake_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (host_load) begin
                host_q  <= host_t'(host_word);
                new_cmd <= 1'b1;
            end
        end
    end

    assign phase_o      = phase;
    assign ptr_o        = ptr_q;
    assign ring_state_o = ring_q.state;
    assign ring_cnt_o   = ring_q.cnt;
    assign ring_zero_o  = ring_zero_q;
    assign wake_req_o   = wake_q;
endmodule

// File: rtl/ring_seq_chk.sv
`timescale 1ns/1ps
module ring_seq_chk
    import ring_seq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               run,
    input logic [1:0]         phase,
    input logic [SLOT_AW-1:0] ptr,
    input logic               load_flag,
    input logic               dly_load,
    input logic [CNT_W-1:0]   ring_cnt,
    input logic               ring_zero,
    input logic               wake
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_phase_order_r1: assert property (@(posedge clk) disable iff (rst)
        (armed && run) |=> (phase == 2'($past(phase) - 2'd1)));

    p_run_low_r8: assert property (@(posedge clk) disable iff (rst)
        (armed && !run) |=> (phase == 2'd0 && !wake && $stable(ptr)));

    p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && run && phase == 2'd1) |=> (ptr == $past(ptr) + SLOT_AW'(1)));

    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && !(run && phase == 2'd1)) |=> $stable(ptr));

    p_dly_capture_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && run && phase == 2'd0) |=> (dly_load == $past(load_flag) && !load_flag));

    p_load_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && load_flag && !$past(load_flag)) |-> ($past(phase) == 2'd2 && $past(run)));

    p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
        armed |-> (ring_zero == (ring_cnt == '0)));
endmodule

bind ring_slot_sequencer ring_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .phase     (phase),
    .ptr       (ptr_q),
    .load_flag (load_flag),
    .dly_load  (dly_load),
    .ring_cnt  (ring_q.cnt),
    .ring_zero (ring_zero_q),
    .wake      (wake_q)
);

// File: tb/ring_slot_sequencer_test.sv
`timescale 1ns/1ps
module ring_slot_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b1;
    logic        host_load = 1'b0;
    logic [15:0] host_word = '0;
    logic [3:0]  dec_state = 4'h0;
    logic        dec_req = 1'b0;
    logic        dec_set_wake = 1'b0;
    logic [1:0]  phase_o;
    logic [3:0]  ptr_o;
    logic [3:0]  ring_state_o;
    logic [7:0]  ring_cnt_o;
    logic        ring_zero_o;
    logic        wake_req_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    ring_slot_sequencer uut (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .host_load    (host_load),
        .host_word    (host_word),
        .dec_state    (dec_state),
        .dec_req      (dec_req),
        .dec_set_wake (dec_set_wake),
        .phase_o      (phase_o),
        .ptr_o        (ptr_o),
        .ring_state_o (ring_state_o),
        .ring_cnt_o   (ring_cnt_o),
        .ring_zero_o  (ring_zero_o),
        .wake_req_o   (wake_req_o)
    );

    always #2.5 clk = ~clk;

    // {host word, slot count before, slot count after}
    localparam logic [31:0] VEC [8] = '{
        32'h312A_00_12,
        32'h3305_12_42,
        32'h7001_00_00,
        32'h7FFF_00_FF,
        32'h7012_FF_00,
        32'h0806_00_80,
        32'hF7F9_00_7F,
        32'h3BE3_42_00
    };

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic to_ph1();
        while (phase_o != 2'd1) @(negedge clk);
    endtask

    task automatic strobe(input logic [15:0] w);
        to_ph1();
        host_word = w;
        host_load = 1'b1;
        clks(1);
        host_load = 1'b0;
    endtask

    initial begin
        logic [7:0] v0;
        logic [7:0] ev;
        logic [3:0] held_ptr;
        clks(3);
        rst = 1'b0;

        // R11 reset state
        chk("R11 phase", phase_o, 1);
        chk("R11 ptr", ptr_o, 0);
        chk("R11 ring count", ring_cnt_o, 0);
        chk("R11 zero flag", ring_zero_o, 1);
        chk("R11 wake", wake_req_o, 0);

        // R1 phase order
        clks(1); chk("R1 phase after 1", phase_o, 0);
        clks(1); chk("R1 phase after 2", phase_o, 3);
        clks(1); chk("R1 phase after 3", phase_o, 2);
        clks(1); chk("R1 phase after 4", phase_o, 1);

        // R2 pointer step and wrap
        chk("R2 ptr after one cycle", ptr_o, 1);
        clks(56); chk("R2 ptr after 15 cycles", ptr_o, 15);
        clks(4);  chk("R2 ptr wraps to 0", ptr_o, 0);

        // R3 R4 R5 R7 R9 host loads from the vector table
        for (int i = 0; i < 8; i++) begin
            strobe(VEC[i][31:16]);
            clks(3);
            chk($sformatf("R7 count before load, vec %0d", i), ring_cnt_o, VEC[i][15:8]);
            clks(4);
            chk($sformatf("R3 R5 loaded count, vec %0d", i), ring_cnt_o, VEC[i][7:0]);
            chk($sformatf("R4 loaded state, vec %0d", i), ring_state_o, VEC[i][19:16]);
            chk($sformatf("R9 zero flag, vec %0d", i), ring_zero_o, (VEC[i][7:0] == 8'h00) ? 1 : 0);
        end

        // R10 wake set and hold
        to_ph1();
        dec_set_wake = 1'b1;
        clks(4);
        chk("R10 wake set at phase 2", wake_req_o, 1);
        dec_set_wake = 1'b0;
        clks(4);
        chk("R10 wake holds", wake_req_o, 1);

        // R8 run low: forced phase 0, wake cleared, pointer held, replayed load
        to_ph1();
        held_ptr = ptr_o;
        run = 1'b0;
        clks(3);
        chk("R8 phase forced to 0", phase_o, 0);
        chk("R8 wake cleared", wake_req_o, 0);
        chk("R8 pointer held", ptr_o, held_ptr);
        run = 1'b1;
        clks(7);
        chk("R8 replayed load count", ring_cnt_o, 8'hBE);
        chk("R8 replayed load state", ring_state_o, 4'h3);

        // R6 decrement sweep with wrap, state from decode
        strobe(16'h7011);
        clks(7);
        chk("R5 load into slot 7", ring_cnt_o, 8'h01);
        dec_state = 4'hC;
        dec_req = 1'b1;
        clks(64);
        for (int w = 0; w < 3; w++) begin
            v0 = ring_cnt_o;
            ev = v0 - 8'd1;
            clks(64);
            chk($sformatf("R6 one decrement per sweep, window %0d", w), ring_cnt_o, ev);
            chk($sformatf("R9 zero flag in sweep, window %0d", w), ring_zero_o, (ev == 8'h00) ? 1 : 0);
            chk($sformatf("R6 state from decode, window %0d", w), ring_state_o, 4'hC);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule